// File: doc/BRIEF.md
# Two-Wire EEPROM Target Read Engine

This block is the target side of a two-wire serial EEPROM holding 64K bytes. It watches the clock and data lines, oversampled by a fast system clock. It recognises its own device address byte and keeps a word-address pointer that survives from one transaction to the next. From that pointer it serves three kinds of read: current-address reads, random reads and sequential reads. It acknowledges on the data line through an open-drain enable, and it shifts read bytes out most significant bit first.

The memory array sits outside the block, behind a synchronous read port. The engine issues a one-cycle read strobe with an address and takes the byte one cycle later. The write path goes only as far as loading the word address through a dummy write. Data bytes that would follow for programming are not acknowledged.

Top module: `eeprom_rd_target`

## Requirements
- R1: A device byte is accepted only when its upper four bits are 1010 and its next three bits equal `dev_sel`. Bit 0 is the direction, with 1 meaning read. An accepted byte is acknowledged by pulling SDA low during the ninth clock. A rejected byte leaves SDA released until the next start condition.
- R2: After an accepted write-direction device byte, two word-address bytes follow, high byte first, and each one is acknowledged. The pointer is loaded only when the low byte completes. A stop after the high byte alone leaves the pointer unchanged. Any further byte after the low byte is not acknowledged.
- R3: A current-address read returns the byte at the pointer and leaves the pointer one higher, for the next transaction.
- R4: A dummy write followed by a repeated start and a read-direction device byte returns the byte at the address just loaded.
- R5: Each master acknowledge (SDA low) after a data byte makes the target send the byte at the next address.
- R6: The pointer wraps from 0xFFFF to 0x0000, both inside a sequential read and across transactions.
- R7: A master non-acknowledge (SDA high) after a data byte ends the read. SDA stays released for any further clocks, and the pointer has advanced past the last byte sent only.
- R8: SDA output changes only while SCL is low, except when a start or stop condition clears it.
- R9: A start condition at any point, even in the middle of a byte, restarts device-address reception.
- R10: `mem_rd` is a single-cycle pulse carrying the fetch address on `mem_addr`. `mem_rdata` is taken one clock after the pulse. `sda_oe` and `mem_rd` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dev_sel | input | 3 | Strap value the device byte must match |
| mem_addr | output | ADDR_W | Array read address |
| mem_rd | output | 1 | One-cycle array read strobe |
| mem_rdata | input | 8 | Array read data, valid one cycle after the strobe |

## Verification
A wrong pointer shows at the ports within one byte time: the next data byte shifted out carries the pattern of a different address. This holds for current-address reads after a stop, and it covers a lost wrap as well. A wrong bit or byte count shows as an acknowledge in the wrong clock slot, or as a missing one, at the ninth SCL pulse of the affected byte. A state machine that fails to leave its transmit state after a non-acknowledge drives data bits on the following clocks, where the bench expects 0xFF from a released line.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO
  } rx_kind_t;

endpackage

// File: rtl/bus_line_sampler.sv
module bus_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe[0] <= 1'b1;
      sda_pipe[0] <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else begin
        scl_pipe[g] <= scl_pipe[g-1];
        sda_pipe[g] <= sda_pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/word_ptr.sv
module word_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load && ptr == {AW{1'b1}}) |=> (ptr == '0)) else $error("pointer wrap"); // R6

endmodule

// File: rtl/eeprom_rd_target.sv
module eeprom_rd_target
  import eeprom_rd_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  FAMILY      = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata
);

  localparam int HI_W = ADDR_W - 8;

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

  tgt_state_t        state;
  rx_kind_t          kind;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [HI_W-1:0]   addr_hi;
  logic              rw;
  logic [7:0]        txbuf;
  logic [2:0]        txidx;
  logic              go_on;
  logic              rd_q;
  logic              ptr_load;
  logic              ptr_step;
  logic [ADDR_W-1:0] ptr_val;
  logic [ADDR_W-1:0] ptr;
  logic              dev_hit;

  bus_line_sampler #(.STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  word_ptr #(.AW(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .step(ptr_step), .ptr(ptr)
  );

  assign dev_hit = (shreg[7:4] == FAMILY) && (shreg[3:1] == dev_sel);

  always_ff @(posedge clk) begin
    mem_rd   <= 1'b0;
    ptr_step <= 1'b0;
    ptr_load <= 1'b0;
    rd_q     <= mem_rd;
    if (rd_q) txbuf <= mem_rdata;
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= RX_DEV;
      bitcnt   <= '0;
      shreg    <= '0;
      addr_hi  <= '0;
      rw       <= 1'b0;
      txbuf    <= '0;
      txidx    <= '0;
      go_on    <= 1'b0;
      rd_q     <= 1'b0;
      sda_oe   <= 1'b0;
      mem_addr <= '0;
      ptr_val  <= '0;
    end else if (start_det) begin
      state  <= ST_RX;
      kind   <= RX_DEV;
      bitcnt <= '0;
      go_on  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      go_on  <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            unique case (kind)
              RX_DEV: begin
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  state  <= ST_ACK;
                  if (shreg[0]) begin
                    mem_rd   <= 1'b1;
                    mem_addr <= ptr;
                    ptr_step <= 1'b1;
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end
              RX_AHI: begin
                addr_hi <= shreg[HI_W-1:0];
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
              end
              default: begin
                ptr_val  <= {addr_hi, shreg};
                ptr_load <= 1'b1;
                sda_oe   <= 1'b1;
                state    <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            if (kind == RX_DEV && rw) begin
              state  <= ST_TX;
              txidx  <= 3'd7;
              sda_oe <= ~txbuf[7];
            end else if (kind == RX_DEV) begin
              state <= ST_RX;
              kind  <= RX_AHI;
            end else if (kind == RX_AHI) begin
              state <= ST_RX;
              kind  <= RX_ALO;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (txidx == 3'd0) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              txidx  <= txidx - 1'b1;
              sda_oe <= ~txbuf[txidx - 1'b1];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (!sda_q) begin
              go_on    <= 1'b1;
              mem_rd   <= 1'b1;
              mem_addr <= ptr;
              ptr_step <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else if (scl_fall && go_on) begin
            go_on  <= 1'b0;
            state  <= ST_TX;
            txidx  <= 3'd7;
            sda_oe <= ~txbuf[7];
          end
        end
        default: ;
      endcase
    end
  end

  AST_MISMATCH_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX && kind == RX_DEV && scl_fall && bitcnt == 4'd8 && shreg[3:1] != dev_sel
     && !start_det && !stop_det) |=> !sda_oe) else $error("ack on foreign address"); // R1
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (ptr == ADDR_W'(mem_addr + 1'b1))) else $error("pointer not advanced"); // R3
  AST_NACK_ENDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK && scl_rise && sda_q && !start_det && !stop_det)
      |=> (state == ST_IDLE && !sda_oe)) else $error("read continues after nack"); // R7
  AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe))
    else $error("sda changed while scl high"); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_RX && kind == RX_DEV && !sda_oe)) else $error("start not honoured"); // R9
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd) else $error("read strobe too long"); // R10

endmodule

// File: tb/eeprom_rd_target_test.sv
`timescale 1ns/1ps
module eeprom_rd_target_test;

  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1;
  logic        m_low = 1'b0;
  logic        sda;
  logic        sda_oe;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0;
  int n_err = 0;
  int r8_viol = 0;
  int r10_viol = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  always #2.5 clk = ~clk;
  assign sda = ~(m_low | sda_oe);

  eeprom_rd_target uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda), .sda_oe(sda_oe),
    .dev_sel(STRAP), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus watchers: R8 sda output stable while scl high, R10 strobe width
  logic prev_oe = 1'b0, prev_scl = 1'b1, prev_rd = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe != prev_oe && m_scl && prev_scl) r8_viol++;
      if (mem_rd && prev_rd) r10_viol++;
    end
    prev_oe  = sda_oe;
    prev_scl = m_scl;
    prev_rd  = mem_rd;
  end

  // scoreboard monitor
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [7:0] a;
        a = act_q.pop_front();
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", a, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(a == e, t, a, e);
        end
      end
    end
  end

  task automatic expect_bytes(input logic [15:0] addr, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(pat(addr + 16'(i)));
      tag_q.push_back(tag);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input bit b, output bit s);
    m_low = ~b; tick(Q);
    m_scl = 1'b1; tick(Q);
    s = sda;
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) send_bit(v[i], s);
    send_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic read_byte(input bit mack);
    logic [7:0] v;
    bit s;
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b1, s);
      v = {v[6:0], s};
    end
    send_bit(~mack, s);
    act_q.push_back(v);
  endtask

  task automatic load_addr(input logic [15:0] a);
    bit ack;
    bus_start();
    write_byte({4'hA, STRAP, 1'b0}, ack); check(ack, "R1 write dev ack", ack, 1);
    write_byte(a[15:8], ack);             check(ack, "R2 high addr ack", ack, 1);
    write_byte(a[7:0], ack);              check(ack, "R2 low addr ack", ack, 1);
  endtask

  task automatic read_open();
    bit ack;
    bus_start();
    write_byte({4'hA, STRAP, 1'b1}, ack); check(ack, "R1 read dev ack", ack, 1);
  endtask

  initial begin
    bit ack, s;
    tick(5);
    rst = 1'b0;
    tick(2);
    check(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    check(mem_rd == 1'b0, "R10 reset mem_rd", mem_rd, 0);

    // R1 foreign strap and foreign family
    bus_start();
    write_byte({4'hA, 3'b010, 1'b1}, ack); check(!ack, "R1 strap mismatch", ack, 0);
    write_byte(8'hFF, ack);                check(!ack, "R1 stays released", ack, 0);
    bus_stop();
    bus_start();
    write_byte({4'hB, STRAP, 1'b1}, ack);  check(!ack, "R1 family mismatch", ack, 0);
    bus_stop();

    // R4 random read
    load_addr(16'h1234);
    read_open();
    expect_bytes(16'h1234, 1, "R4 random read");
    read_byte(1'b0);
    bus_stop();

    // R3 current-address read
    read_open();
    expect_bytes(16'h1235, 1, "R3 current read");
    read_byte(1'b0);
    bus_stop();

    // R5 sequential read across a low-byte boundary
    load_addr(16'h00FE);
    read_open();
    expect_bytes(16'h00FE, 4, "R5 sequential");
    read_byte(1'b1); read_byte(1'b1); read_byte(1'b1); read_byte(1'b0);
    bus_stop();

    // R6 wrap inside a burst and across transactions
    load_addr(16'hFFFE);
    read_open();
    expect_bytes(16'hFFFE, 3, "R6 wrap burst");
    read_byte(1'b1); read_byte(1'b1); read_byte(1'b0);
    bus_stop();
    read_open();
    expect_bytes(16'h0001, 1, "R6 wrap persists");
    read_byte(1'b0);
    bus_stop();

    // R7 nack ends the read: further clocks see a released line
    read_open();
    expect_bytes(16'h0002, 1, "R7 last byte");
    read_byte(1'b0);
    exp_q.push_back(8'hFF); tag_q.push_back("R7 released after nack");
    read_byte(1'b0);
    bus_stop();
    read_open();
    expect_bytes(16'h0003, 1, "R7 pointer after nack");
    read_byte(1'b0);
    bus_stop();

    // R9 start in the middle of a byte
    bus_start();
    send_bit(1'b1, s); send_bit(1'b0, s); send_bit(1'b1, s); send_bit(1'b0, s);
    read_open();
    expect_bytes(16'h0004, 1, "R9 restart mid byte");
    read_byte(1'b0);
    bus_stop();

    // R2 high byte only then stop: pointer unchanged
    bus_start();
    write_byte({4'hA, STRAP, 1'b0}, ack); check(ack, "R2 dev ack", ack, 1);
    write_byte(8'h55, ack);               check(ack, "R2 lone high byte ack", ack, 1);
    bus_stop();
    read_open();
    expect_bytes(16'h0005, 1, "R2 partial load ignored");
    read_byte(1'b0);
    bus_stop();

    // R2 data byte after the address is not acknowledged
    load_addr(16'h0100);
    write_byte(8'h77, ack); check(!ack, "R2 extra byte nacked", ack, 0);
    bus_stop();
    read_open();
    expect_bytes(16'h0100, 1, "R4 address after dummy write");
    read_byte(1'b0);
    bus_stop();

    tick(20);
    wait (act_q.size() == 0);
    tick(2);
    check(exp_q.size() == 0, "R5 all expected bytes seen", exp_q.size(), 0);
    check(r8_viol == 0, "R8 sda stable while scl high", r8_viol, 0);
    check(r10_viol == 0, "R10 single-cycle strobe", r10_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog (R1 to R10 run): actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule